// File: doc/BRIEF.md
# Scoreboard Issue Controller for Ten Fixed-Latency Functional Units

This block decides, every clock, whether the decoded instruction at its input may start. Ten functional units are available: branch, Boolean, shift, long integer add, floating add, floating divide, two floating multipliers and two increment units. Each unit has a fixed latency. The arithmetic is not modelled; each unit is only a countdown that marks the unit busy for its latency and then reports completion.

The controller keeps one busy flag per unit and, for each register, a pending flag with the number of the unit that will write it. An instruction starts only when a unit of its class is idle, its destination has no outstanding writer, and neither of its sources has one. Otherwise the instruction is held at the input. The upstream stage keeps `in_valid` and the instruction fields stable until `issue` is seen. When a unit finishes, its busy flag and the pending flag of its destination register clear together. A held instruction can start in the cycle after that.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset, every unit is idle and no register is pending. With `in_valid` low, `issue` is low and `done_mask` is zero. The first valid instruction issues in the cycle it is presented.
- R2: An instruction issues only when a unit of its class is idle. A second instruction for a busy single-unit class waits until the cycle after that unit completes.
- R3: The class code on `in_cls` selects the unit. Class 0 goes to unit 0 (branch), 1 to unit 1 (Boolean), 2 to unit 2 (shift), 3 to unit 3 (long add), 4 to unit 4 (floating add) and 5 to unit 5 (floating divide). Class 6 goes to multiplier unit 6 or 7. Class 7 goes to increment unit 8 or 9. For class 6 or 7, the lower-numbered idle unit wins, and the instruction stalls only when both units are busy.
- R4: An instruction whose destination register already has a pending writer stalls until that writer completes (write-after-write).
- R5: An instruction whose first or second source register has a pending writer stalls until that writer completes (read-after-write).
- R6: Bit u of `done_mask` rises exactly L cycles after the cycle in which unit u issued, where L is that unit's latency. The defaults are 4 for floating add, 10 for each multiplier, 29 for divide, 3 for each increment unit, and 3 for branch, Boolean, shift and long add.
- R7: Completion clears the unit's busy flag and its destination's pending flag in the same cycle. A stalled instruction issues in the next cycle, never in the completion cycle itself.
- R8: At most one instruction issues per cycle. `issue` is a combinational response within the cycle, and `issue_unit` names the chosen unit while `issue` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present, held until issued |
| in_cls | input | 3 | Unit class code (see R3) |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src_a | input | $clog2(NREG) | First source register |
| in_src_b | input | $clog2(NREG) | Second source register |
| issue | output | 1 | Instruction accepted and started this cycle |
| issue_unit | output | 4 | Unit index chosen for the instruction |
| done_mask | output | 10 | One bit per unit, high in its completion cycle |

## Verification
Some properties are checked by assertions on every cycle:
- A unit is never started while it is busy.
- A unit is always released the cycle after it reports completion.
- Each countdown steps down by exactly one per cycle.
- No issue ever lands on a register with a pending writer, whether through the destination or through a source.

Other behaviours need the bench's directed scenarios:
- The exact issue cycle after a stall.
- Which of the two duplicated units is picked.
- The absolute completion latency of each unit class.

The bench checks these against cycle numbers it computes itself.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int NUM_UNITS  = 10;
   localparam int UNIT_IDX_W = 4;

   typedef enum logic [2:0] {
      CLS_BRANCH = 3'd0,
      CLS_BOOL   = 3'd1,
      CLS_SHIFT  = 3'd2,
      CLS_LADD   = 3'd3,
      CLS_FADD   = 3'd4,
      CLS_FDIV   = 3'd5,
      CLS_FMUL   = 3'd6,
      CLS_INCR   = 3'd7
   } unit_cls_e;

   localparam int U_BRANCH = 0;
   localparam int U_BOOL   = 1;
   localparam int U_SHIFT  = 2;
   localparam int U_LADD   = 3;
   localparam int U_FADD   = 4;
   localparam int U_FDIV   = 5;
   localparam int U_FMUL0  = 6;
   localparam int U_FMUL1  = 7;
   localparam int U_INCR0  = 8;
   localparam int U_INCR1  = 9;
endpackage

// File: rtl/sb_unit_timer.sv
module sb_unit_timer #(
   parameter int LAT = 3,
   parameter int CW  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

   generate
      if (LAT < 1 || LAT >= (1 << CW)) begin : g_bad_lat
         $error("sb_unit_timer: LAT out of range for counter width");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= LOAD;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - CW'(1);
      end
   end

   assign done = busy && (cnt_q == '0);

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);                                              // R2
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);                                               // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !start) |=> (busy && cnt_q == $past(cnt_q) - CW'(1))); // R6
endmodule

// File: rtl/sb_unit_select.sv
module sb_unit_select
   import sb_pkg::*;
(
   input  logic [2:0]            cls,
   input  logic [NUM_UNITS-1:0]  busy_vec,
   output logic                  pick_ok,
   output logic [UNIT_IDX_W-1:0] pick_idx
);
   always_comb begin
      pick_ok  = 1'b0;
      pick_idx = '0;
      case (unit_cls_e'(cls))
         CLS_BRANCH: begin pick_idx = UNIT_IDX_W'(U_BRANCH); pick_ok = !busy_vec[U_BRANCH]; end
         CLS_BOOL:   begin pick_idx = UNIT_IDX_W'(U_BOOL);   pick_ok = !busy_vec[U_BOOL];   end
         CLS_SHIFT:  begin pick_idx = UNIT_IDX_W'(U_SHIFT);  pick_ok = !busy_vec[U_SHIFT];  end
         CLS_LADD:   begin pick_idx = UNIT_IDX_W'(U_LADD);   pick_ok = !busy_vec[U_LADD];   end
         CLS_FADD:   begin pick_idx = UNIT_IDX_W'(U_FADD);   pick_ok = !busy_vec[U_FADD];   end
         CLS_FDIV:   begin pick_idx = UNIT_IDX_W'(U_FDIV);   pick_ok = !busy_vec[U_FDIV];   end
         CLS_FMUL: begin
            pick_ok = !busy_vec[U_FMUL0] || !busy_vec[U_FMUL1];
            pick_idx = !busy_vec[U_FMUL0] ? UNIT_IDX_W'(U_FMUL0) : UNIT_IDX_W'(U_FMUL1);
         end
         default: begin
            pick_ok = !busy_vec[U_INCR0] || !busy_vec[U_INCR1];
            pick_idx = !busy_vec[U_INCR0] ? UNIT_IDX_W'(U_INCR0) : UNIT_IDX_W'(U_INCR1);
         end
      endcase
   end
endmodule

// File: rtl/sb_reg_tracker.sv
module sb_reg_tracker #(
   parameter int NREG = 24,
   parameter int RW   = 5,
   parameter int NU   = 10,
   parameter int TW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [RW-1:0] set_reg,
   input  logic [TW-1:0] set_tag,
   input  logic [NU-1:0] done_vec,
   input  logic [RW-1:0] rd_dst,
   input  logic [RW-1:0] rd_a,
   input  logic [RW-1:0] rd_b,
   output logic          hz_dst,
   output logic          hz_src
);
   localparam int NSLOT = 1 << RW;
   localparam int NTAG  = 1 << TW;

   generate
      if (NREG < 2 || NREG > NSLOT) begin : g_bad_nreg
         $error("sb_reg_tracker: NREG does not fit register index width");
      end
      if (NU > NTAG) begin : g_bad_tag
         $error("sb_reg_tracker: tag width too small for unit count");
      end
   endgenerate

   logic [NSLOT-1:0] pend_ext;
   logic [NTAG-1:0]  done_ext;
   logic [TW-1:0]    tag_q [NREG];

   always_comb begin
      done_ext             = '0;
      done_ext[NU-1:0]     = done_vec;
   end

   generate
      for (genvar r = 0; r < NSLOT; r++) begin : g_reg
         if (r < NREG) begin : g_live
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  pend_ext[r] <= 1'b0;
                  tag_q[r]    <= '0;
               end else if (set_en && set_reg == RW'(r)) begin
                  pend_ext[r] <= 1'b1;
                  tag_q[r]    <= set_tag;
               end else if (pend_ext[r] && done_ext[tag_q[r]]) begin
                  pend_ext[r] <= 1'b0;
               end
            end
         end else begin : g_absent
            assign pend_ext[r] = 1'b0;
         end
      end
   endgenerate

   assign hz_dst = pend_ext[rd_dst];
   assign hz_src = pend_ext[rd_a] || pend_ext[rd_b];

   AST_NO_WAW: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !pend_ext[set_reg]);                                // R4
   AST_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> (!pend_ext[rd_a] && !pend_ext[rd_b]));              // R5
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
   import sb_pkg::*;
#(
   parameter int NREG       = 24,
   parameter int LAT_BRANCH = 3,
   parameter int LAT_BOOL   = 3,
   parameter int LAT_SHIFT  = 3,
   parameter int LAT_LADD   = 3,
   parameter int LAT_FADD   = 4,
   parameter int LAT_FMUL   = 10,
   parameter int LAT_FDIV   = 29,
   parameter int LAT_INCR   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [2:0]                in_cls,
   input  logic [$clog2(NREG)-1:0]   in_dst,
   input  logic [$clog2(NREG)-1:0]   in_src_a,
   input  logic [$clog2(NREG)-1:0]   in_src_b,
   output logic                      issue,
   output logic [UNIT_IDX_W-1:0]     issue_unit,
   output logic [NUM_UNITS-1:0]      done_mask
);
   localparam int RW = $clog2(NREG);

   function automatic int unit_lat(input int u);
      case (u)
         U_BRANCH:         return LAT_BRANCH;
         U_BOOL:           return LAT_BOOL;
         U_SHIFT:          return LAT_SHIFT;
         U_LADD:           return LAT_LADD;
         U_FADD:           return LAT_FADD;
         U_FDIV:           return LAT_FDIV;
         U_FMUL0, U_FMUL1: return LAT_FMUL;
         default:          return LAT_INCR;
      endcase
   endfunction

   function automatic int max_lat();
      int m = 1;
      for (int u = 0; u < NUM_UNITS; u++) if (unit_lat(u) > m) m = unit_lat(u);
      return m;
   endfunction

   localparam int CW = $clog2(max_lat() + 1);

   logic [NUM_UNITS-1:0]  busy_vec;
   logic [NUM_UNITS-1:0]  done_vec;
   logic [NUM_UNITS-1:0]  start_vec;
   logic                  pick_ok;
   logic [UNIT_IDX_W-1:0] pick_idx;
   logic                  hz_dst;
   logic                  hz_src;

   sb_unit_select u_select (
      .cls      (in_cls),
      .busy_vec (busy_vec),
      .pick_ok  (pick_ok),
      .pick_idx (pick_idx)
   );

   sb_reg_tracker #(
      .NREG (NREG),
      .RW   (RW),
      .NU   (NUM_UNITS),
      .TW   (UNIT_IDX_W)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (issue),
      .set_reg  (in_dst),
      .set_tag  (pick_idx),
      .done_vec (done_vec),
      .rd_dst   (in_dst),
      .rd_a     (in_src_a),
      .rd_b     (in_src_b),
      .hz_dst   (hz_dst),
      .hz_src   (hz_src)
   );

   assign issue = in_valid && pick_ok && !hz_dst && !hz_src;

   always_comb begin
      start_vec = '0;
      if (issue) start_vec[pick_idx] = 1'b1;
   end

   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
         sb_unit_timer #(
            .LAT (unit_lat(u)),
            .CW  (CW)
         ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start_vec[u]),
            .busy  (busy_vec[u]),
            .done  (done_vec[u])
         );
      end
   endgenerate

   assign issue_unit = pick_idx;
   assign done_mask  = done_vec;

   AST_ISSUE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> in_valid);                                           // R8
   AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vec != '0) |-> ((done_vec & ~busy_vec) == '0));          // R6
endmodule

// File: tb/sb_issue_ctrl_bench.sv
`timescale 1ns/1ps
module sb_issue_ctrl_bench;
   import sb_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_cls = '0;
   logic [4:0] in_dst = '0;
   logic [4:0] in_src_a = '0;
   logic [4:0] in_src_b = '0;
   logic       issue;
   logic [3:0] issue_unit;
   logic [9:0] done_mask;

   always #2 clk = ~clk;

   sb_issue_ctrl u_sb_issue_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .issue(issue), .issue_unit(issue_unit), .done_mask(done_mask)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int unit; int when; } exp_t;
   exp_t expq[$];
   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int lat_of(input int u);
      case (u)
         4: return 4;
         5: return 29;
         6, 7: return 10;
         default: return 3;
      endcase
   endfunction

   task automatic send(input int c, input int d, input int a, input int b,
                       output int t_req, output int t_iss, output int u_iss);
      @(negedge clk);
      in_valid = 1'b1; in_cls = 3'(c); in_dst = 5'(d);
      in_src_a = 5'(a); in_src_b = 5'(b);
      #0.5;
      t_req = cyc;
      while (!issue) begin
         @(negedge clk);
         #0.5;
      end
      t_iss = cyc;
      u_iss = int'(issue_unit);
      expq.push_back('{u_iss, t_iss + lat_of(u_iss)});
      @(posedge clk);
      #0.5 in_valid = 1'b0;
   endtask

   // monitor: pops expected completions as they appear
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         for (int u = 0; u < 10; u++) begin
            if (done_mask[u]) begin
               int idx = -1;
               for (int k = 0; k < expq.size(); k++)
                  if (idx < 0 && expq[k].unit == u) idx = k;
               if (idx < 0) check(1'b0, "R6", "unexpected completion unit", u, -1);
               else begin
                  check(cyc == expq[idx].when, "R6", "completion cycle", cyc, expq[idx].when);
                  expq.delete(idx);
               end
            end
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   task automatic drain();
      repeat (40) @(negedge clk);
   endtask

   initial begin
      int tr, ti, u, t_a, t_b;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #0.5;
      check(issue == 1'b0, "R1", "issue idle", int'(issue), 0);
      check(done_mask == '0, "R1", "done_mask idle", int'(done_mask), 0);

      // R1/R3: first instruction issues at once on floating add
      send(4, 1, 10, 11, tr, ti, u);
      check(ti == tr, "R1", "first issue cycle", ti, tr);
      check(u == 4, "R3", "fadd unit", u, 4);

      // R3: duplicated multipliers
      send(6, 2, 0, 0, tr, t_a, u);
      check(u == 6, "R3", "fmul low unit", u, 6);
      send(6, 3, 0, 0, tr, ti, u);
      check(u == 7 && ti == tr, "R3", "fmul second unit", u, 7);
      send(6, 4, 0, 0, tr, ti, u);
      check(ti == t_a + 11, "R7", "fmul reissue cycle", ti, t_a + 11);
      check(u == 6, "R3", "fmul freed unit", u, 6);
      drain();

      // R5: read-after-write on source a and source b
      send(5, 6, 0, 0, tr, t_a, u);
      check(u == 5, "R3", "fdiv unit", u, 5);
      send(7, 7, 6, 0, tr, t_b, u);
      check(t_b == t_a + 30, "R5", "src_a stall release", t_b, t_a + 30);
      check(u == 8, "R3", "incr low unit", u, 8);
      send(3, 9, 0, 7, tr, ti, u);
      check(ti == t_b + 4, "R5", "src_b stall release", ti, t_b + 4);
      check(u == 3, "R3", "ladd unit", u, 3);

      // R4: write-after-write
      send(2, 12, 0, 0, tr, t_a, u);
      check(u == 2, "R3", "shift unit", u, 2);
      send(1, 12, 0, 0, tr, ti, u);
      check(ti == t_a + 4, "R4", "waw stall release", ti, t_a + 4);
      check(u == 1, "R3", "bool unit", u, 1);

      // R2: busy single unit
      send(4, 13, 0, 0, tr, t_a, u);
      send(4, 14, 0, 0, tr, ti, u);
      check(ti == t_a + 5, "R2", "busy unit stall release", ti, t_a + 5);
      check(ti > tr, "R2", "busy unit stalled", ti, tr + 1);
      drain();

      // R3/R8: increment pair and branch, one per cycle
      send(7, 15, 0, 0, tr, t_a, u);
      check(u == 8, "R3", "incr first", u, 8);
      send(7, 16, 0, 0, tr, ti, u);
      check(u == 9 && ti == tr, "R3", "incr second", u, 9);
      check(ti == t_a + 1, "R8", "one issue per cycle spacing", ti, t_a + 1);
      send(0, 17, 0, 0, tr, ti, u);
      check(u == 0 && ti == tr, "R3", "branch unit", u, 0);
      drain();

      check(expq.size() == 0, "R6", "completions outstanding", expq.size(), 0);
      summary();
      $finish;
   end
endmodule